// File: doc/BRIEF.md
# Alternate Mark Inversion Line Codec

This block converts a binary bit stream into a three-level line signal and back again. The line is carried as two digital rails: one rail marks a positive pulse and the other marks a negative pulse. When neither rail is active, the line is at the zero level. The encoder turns each input bit into one symbol. Successive marks alternate in polarity, which keeps the line free of a DC build-up. The decoder takes two rail inputs and rebuilds the bit stream from them.

The decoder also watches the line for damage. A mark that repeats the polarity of the mark before it breaks the alternation rule, and it is flagged. This matters because any single corrupted symbol produces such a break somewhere downstream, although not always at the corrupted bit itself. The decoder also flags a run of zero-level symbols that is longer than the allowed limit, since such a run starves clock recovery. Finally, it flags symbols in which both rails are active.

A mode input swaps the meaning of the two bit values. In this swapped mode, zeros are the ones that alternate and ones are sent as the zero level. Work happens only in clock cycles where the enable input is high, and one bit is handled per enabled cycle.

Top module: `ami_codec`

## Requirements
- R1: After reset, both transmit rails are low, rx_valid and every decoder flag are low, the first mark sent is positive, and the first mark received is never flagged as a violation.
- R2: With inv_mode=0, a 1 input is sent as a mark whose polarity is opposite to the previous mark, and a 0 input is sent with both rails low. The symbol appears on tx_pos/tx_neg after the clock edge at which en is high.
- R3: The encoder never drives tx_pos and tx_neg high in the same cycle.
- R4: With inv_mode=1, a 0 input is sent as an alternating mark and a 1 input is sent as the zero level. The alternation state carries across a mode change.
- R5: rx_valid is high for exactly one cycle after each edge at which en is high. On that cycle, rx_bit is 1 for a mark and 0 for the zero level when inv_mode=0, and the inverse when inv_mode=1.
- R6: A received mark with the same polarity as the previous received mark raises rx_bpv. That mark still decodes as a mark and becomes the new polarity reference.
- R7: The 16th and every later consecutive zero-level symbol raise rx_zrun, for MAX_ZERO_RUN=15. A mark clears the run count and never raises rx_zrun.
- R8: A symbol with both receive rails high raises rx_invalid and decodes as the zero-level value. It changes neither the polarity reference nor the zero-run count.
- R9: While en is low, the transmit rails hold their value and rx_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Bit enable: one bit is encoded and one symbol decoded per high cycle |
| inv_mode | input | 1 | 0: ones are marks; 1: zeros are marks |
| tx_bit | input | 1 | Bit to encode |
| tx_pos | output | 1 | Encoded positive-pulse rail |
| tx_neg | output | 1 | Encoded negative-pulse rail |
| rx_pos | input | 1 | Received positive-pulse rail |
| rx_neg | input | 1 | Received negative-pulse rail |
| rx_valid | output | 1 | Decoded result present |
| rx_bit | output | 1 | Decoded bit |
| rx_bpv | output | 1 | Alternation rule broken by this mark |
| rx_zrun | output | 1 | Zero-level run longer than the limit |
| rx_invalid | output | 1 | Both rails were active |

## Verification
The run counter is cleared and the polarity check is made in the same cycle when a mark ends an overlong run of zero-level symbols. The bench provokes this by sending seventeen zero-level symbols after a negative mark, followed by another negative mark. It expects rx_bpv high and rx_zrun low on that mark, and expects the zero-level symbols that follow to count again from one, so that no flag appears until the sixteenth of them. An invalid symbol placed inside a run is judged the same way: the decoder must neither restart nor extend the run.

// File: rtl/ami_pkg.sv
package ami_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_POS  = 2'd1,
        SYM_NEG  = 2'd2,
        SYM_BAD  = 2'd3
    } sym_e;

    function automatic sym_e classify(input logic p, input logic n);
        sym_e s;
        case ({p, n})
            2'b10:   s = SYM_POS;
            2'b01:   s = SYM_NEG;
            2'b11:   s = SYM_BAD;
            default: s = SYM_ZERO;
        endcase
        return s;
    endfunction

    typedef struct packed {
        logic pos;
        logic neg;
        logic next_neg;
    } enc_state_t;

endpackage

// File: rtl/ami_encoder.sv
module ami_encoder
    import ami_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic inv_mode,
    input  logic data_in,
    output logic line_pos,
    output logic line_neg
);

    enc_state_t st_d, st_q;
    logic       mark;

    always_comb begin
        st_d = st_q;
        mark = data_in ^ inv_mode;
        if (en) begin
            st_d.pos = mark & ~st_q.next_neg;
            st_d.neg = mark & st_q.next_neg;
            if (mark) begin
                st_d.next_neg = ~st_q.next_neg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_pos = st_q.pos;
    assign line_neg = st_q.neg;

endmodule

// File: rtl/ami_decoder.sv
module ami_decoder
    import ami_pkg::*;
#(
    parameter int MAX_ZERO_RUN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic inv_mode,
    input  logic line_pos,
    input  logic line_neg,
    output logic out_valid,
    output logic out_bit,
    output logic out_bpv,
    output logic out_zrun,
    output logic out_bad
);

    localparam int RUN_W = $clog2(MAX_ZERO_RUN + 2);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(MAX_ZERO_RUN + 1);
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(MAX_ZERO_RUN);

    typedef struct packed {
        logic             valid;
        logic             dat;
        logic             bpv;
        logic             zrun;
        logic             bad;
        logic             seen;
        logic             last_neg;
        logic [RUN_W-1:0] run;
    } dec_state_t;

    dec_state_t       st_d, st_q;
    sym_e             sym;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        st_d       = st_q;
        st_d.valid = en;
        st_d.dat   = 1'b0;
        st_d.bpv   = 1'b0;
        st_d.zrun  = 1'b0;
        st_d.bad   = 1'b0;
        sym        = classify(line_pos, line_neg);
        run_inc    = (st_q.run == RUN_SAT) ? st_q.run : st_q.run + 1'b1;
        if (en) begin
            case (sym)
                SYM_BAD: begin
                    st_d.bad = 1'b1;
                    st_d.dat = inv_mode;
                end
                SYM_POS, SYM_NEG: begin
                    st_d.dat      = ~inv_mode;
                    st_d.bpv      = st_q.seen && (st_q.last_neg == (sym == SYM_NEG));
                    st_d.last_neg = (sym == SYM_NEG);
                    st_d.seen     = 1'b1;
                    st_d.run      = '0;
                end
                default: begin
                    st_d.dat  = inv_mode;
                    st_d.run  = run_inc;
                    st_d.zrun = run_inc > RUN_LIM;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_bit   = st_q.dat;
    assign out_bpv   = st_q.bpv;
    assign out_zrun  = st_q.zrun;
    assign out_bad   = st_q.bad;

endmodule

// File: rtl/ami_codec.sv
module ami_codec #(
    parameter int MAX_ZERO_RUN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic inv_mode,
    input  logic tx_bit,
    output logic tx_pos,
    output logic tx_neg,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic rx_valid,
    output logic rx_bit,
    output logic rx_bpv,
    output logic rx_zrun,
    output logic rx_invalid
);

    ami_encoder u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .inv_mode (inv_mode),
        .data_in  (tx_bit),
        .line_pos (tx_pos),
        .line_neg (tx_neg)
    );

    ami_decoder #(
        .MAX_ZERO_RUN (MAX_ZERO_RUN)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .inv_mode  (inv_mode),
        .line_pos  (rx_pos),
        .line_neg  (rx_neg),
        .out_valid (rx_valid),
        .out_bit   (rx_bit),
        .out_bpv   (rx_bpv),
        .out_zrun  (rx_zrun),
        .out_bad   (rx_invalid)
    );

endmodule

// File: rtl/ami_codec_chk.sv
module ami_codec_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic inv_mode,
    input logic tx_pos,
    input logic tx_neg,
    input logic rx_valid,
    input logic rx_bit,
    input logic rx_bpv,
    input logic rx_zrun,
    input logic rx_invalid
);

    p_rails_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_pos && tx_neg));

    p_valid_after_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> rx_valid);

    p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rx_valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(tx_pos) && $stable(tx_neg)));

    p_flags_need_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> !(rx_bpv || rx_zrun || rx_invalid));

    p_bpv_is_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bpv |-> (rx_bit != $past(inv_mode)));

    p_zrun_is_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_zrun |-> (rx_bit == $past(inv_mode)));

    p_flags_disjoint_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rx_bpv, rx_zrun, rx_invalid}) <= 1);

endmodule

bind ami_codec ami_codec_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .inv_mode   (inv_mode),
    .tx_pos     (tx_pos),
    .tx_neg     (tx_neg),
    .rx_valid   (rx_valid),
    .rx_bit     (rx_bit),
    .rx_bpv     (rx_bpv),
    .rx_zrun    (rx_zrun),
    .rx_invalid (rx_invalid)
);

// File: tb/sim_ami_codec.sv
module sim_ami_codec;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic inv_mode = 1'b0;
    logic tx_bit = 1'b0;
    logic rx_pos = 1'b0;
    logic rx_neg = 1'b0;
    logic tx_pos, tx_neg, rx_valid, rx_bit, rx_bpv, rx_zrun, rx_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ami_codec u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .inv_mode(inv_mode), .tx_bit(tx_bit),
        .tx_pos(tx_pos), .tx_neg(tx_neg), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_bpv(rx_bpv),
        .rx_zrun(rx_zrun), .rx_invalid(rx_invalid)
    );

    typedef struct {
        logic  b;
        logic  bpv;
        logic  zrun;
        logic  bad;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // bench-side model state
    logic m_next_neg = 1'b0;
    logic m_seen = 1'b0;
    logic m_last_neg = 1'b0;
    int   m_run = 0;

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per decoded result
    always @(negedge clk) begin
        if (rst_n && rx_valid && !done) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R5 unexpected rx_valid actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rx_bit,     e.b,    {e.tag, " rx_bit"});
                chk(rx_bpv,     e.bpv,  {e.tag, " rx_bpv"});
                chk(rx_zrun,    e.zrun, {e.tag, " rx_zrun"});
                chk(rx_invalid, e.bad,  {e.tag, " rx_invalid"});
            end
        end
    end

    // driver: one enabled cycle, encoder and decoder expectations computed from the requirements
    task automatic send(input logic b, input logic p, input logic n, input string tag);
        logic mark;
        logic ep, en_exp;
        exp_t e;
        @(negedge clk);
        en = 1'b1; tx_bit = b; rx_pos = p; rx_neg = n;
        mark   = b ^ inv_mode;
        ep     = mark && !m_next_neg;
        en_exp = mark && m_next_neg;
        if (mark) m_next_neg = !m_next_neg;
        e.tag = tag; e.bpv = 1'b0; e.zrun = 1'b0; e.bad = 1'b0;
        if (p && n) begin
            e.bad = 1'b1; e.b = inv_mode;
        end else if (p ^ n) begin
            e.b = !inv_mode;
            e.bpv = m_seen && (m_last_neg == n);
            m_seen = 1'b1; m_last_neg = n; m_run = 0;
        end else begin
            e.b = inv_mode;
            if (m_run < 16) m_run++;
            e.zrun = (m_run > 15);
        end
        exp_q.push_back(e);
        @(negedge clk);
        en = 1'b0;
        chk(tx_pos, ep,     {tag, " tx_pos"});
        chk(tx_neg, en_exp, {tag, " tx_neg"});
    endtask

    // loopback: receive rails carry what the encoder is expected to send for this bit
    task automatic loop(input logic b, input string tag);
        logic mark;
        mark = b ^ inv_mode;
        send(b, mark && !m_next_neg, mark && m_next_neg, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_pos, 1'b0, "R1 reset tx_pos");
        chk(tx_neg, 1'b0, "R1 reset tx_neg");
        chk(rx_valid, 1'b0, "R1 reset rx_valid");
        rst_n = 1'b1;

        // R2 R5 R1: normal mode, first mark positive
        loop(1'b1, "R1 first mark");
        loop(1'b0, "R2 zero");
        loop(1'b1, "R2 one");
        loop(1'b1, "R2 one");
        loop(1'b0, "R2 zero");
        loop(1'b1, "R2 one");

        // R4: inverted mode, state carried over
        inv_mode = 1'b1;
        loop(1'b0, "R4 zero mark");
        loop(1'b1, "R4 one space");
        loop(1'b0, "R4 zero mark");
        loop(1'b0, "R4 zero mark");
        loop(1'b1, "R4 one space");
        inv_mode = 1'b0;

        // R6: violations, violating mark becomes reference
        send(1'b0, 1'b1, 1'b0, "R6 pos");
        send(1'b0, 1'b1, 1'b0, "R6 repeat pos");
        send(1'b0, 1'b0, 1'b1, "R6 neg after bpv");
        send(1'b0, 1'b0, 1'b1, "R6 repeat neg");

        // R7: overlong run, then violating mark ending it
        for (int i = 0; i < 17; i++) send(1'b0, 1'b0, 1'b0, "R7 run");
        send(1'b0, 1'b0, 1'b1, "R7 R6 mark ends run");
        for (int i = 0; i < 16; i++) send(1'b0, 1'b0, 1'b0, "R7 run restart");

        // R8: invalid keeps reference and run count
        send(1'b0, 1'b1, 1'b0, "R8 pos");
        send(1'b0, 1'b1, 1'b1, "R8 both rails");
        send(1'b0, 1'b1, 1'b0, "R8 pos after invalid");
        for (int i = 0; i < 15; i++) send(1'b0, 1'b0, 1'b0, "R8 run");
        send(1'b0, 1'b1, 1'b1, "R8 invalid in run");
        send(1'b0, 1'b0, 1'b0, "R8 run 16th");

        // R9: idle holds
        send(1'b1, 1'b0, 1'b0, "R9 set mark");
        begin
            logic hp, hn;
            hp = tx_pos; hn = tx_neg;
            tx_bit = 1'b1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk(rx_valid, 1'b0, "R9 idle rx_valid");
                chk(tx_pos, hp, "R9 idle tx_pos");
                chk(tx_neg, hn, "R9 idle tx_neg");
            end
        end
        chk(exp_q.size() == 0, 1'b1, "R5 all results seen");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule